// File: doc/BRIEF.md
# Averaging Voltage Scan Monitor with Limit Alarms

This block runs a multiplexed 10-bit ADC over seven voltage channels in a fixed rotation. For each channel it points the analog multiplexer at the input and then runs sixteen conversions, handshaking each one through a start pulse and a done strobe. It adds the sixteen samples together and stores the upper eight bits of the mean as that channel's reading. A nominal supply is expected to convert near 768, three quarters of full scale.

Every new reading is compared with two limits for its channel, a floor and a ceiling, both programmable. A reading that lies outside them sets a sticky status bit for that channel. The status bits are cleared when they are read. A single alert output is raised while any status bit is set and the alert enable is high. The limits reset to the widest possible window, so no alarm can fire until software narrows them. Software reads the readings, limits and status, and writes the limits, through a simple synchronous register port.

Top module: `volt_scan_monitor`

## Requirements
- R1: After reset, every reading reads 0x00, every floor limit 0x00, every ceiling limit 0xFF, the status register 0x00 and alert is low.
- R2: While mon_en is high, channels are measured in the order 0,1,...,6 and then wrap to 0. mux_sel equals the channel index and stays fixed for all sixteen conversions of that channel.
- R3: A reading is bits [13:6] of the 14-bit sum of the channel's sixteen samples, which is the mean shifted right by two.
- R4: The register map is as follows. Reading n is at 0x00+n and is read-only, so a write to it has no effect. The floor limit n is at 0x10+n. The ceiling limit n is at 0x18+n. Status is at 0x20, with bit n belonging to channel n. reg_rdata is valid on the cycle after reg_rd.
- R5: A reading strictly above its ceiling, or strictly below its floor, sets status bit n. A reading equal to a limit does not set it.
- R6: With the reset limits, no status bit is ever set, even for readings of 0x00 and 0xFF.
- R7: Status bits are sticky until status is read. A read returns the value held before the clear. A violation that lands in the same cycle as the read survives the clear.
- R8: alert is registered and equals alert_en AND the OR of the status bits, one cycle late.
- R9: When mon_en falls, the measurement in progress still completes its sixteen conversions, and then no further adc_start is issued.
- R10: adc_start is a one-cycle pulse. It is not issued again until adc_done has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Scan enable, sampled at measurement boundaries |
| alert_en | input | 1 | Global alert enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after reg_rd |
| adc_start | output | 1 | Conversion start pulse |
| adc_done | input | 1 | Conversion complete strobe |
| adc_data | input | 10 | Conversion result, valid with adc_done |
| mux_sel | output | 3 | Analog multiplexer channel select |
| alert | output | 1 | Limit alarm output |

## Verification
The assertions check these rules on every cycle:
- the start/done handshake: a single-cycle start, and no second start while one is outstanding;
- that mux_sel holds steady during an outstanding conversion;
- that exactly sixteen done strobes come before each stored result;
- that a status bit can only rise on a cycle that carries a new result;
- the gating of alert by alert_en.

The directed scenarios show the things a property cannot reach:
- the actual rotation order;
- the arithmetic of the averaged reading;
- the strict inequality at the limit boundary;
- the silence of the reset limits at both ends of the scale;
- clear-on-read;
- the completion of a measurement after the enable is dropped.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_t;

  localparam logic [7:0] MAP_READING = 8'h00;
  localparam logic [7:0] MAP_FLOOR   = 8'h10;
  localparam logic [7:0] MAP_CEIL    = 8'h18;
  localparam logic [7:0] MAP_STATUS  = 8'h20;

  // true when addr falls in the 8-entry window at base and indexes a real channel
  function automatic logic in_window(input logic [7:0] addr, input logic [7:0] base,
                                     input int unsigned nch);
    return (addr[7:3] == base[7:3]) && ({1'b0, addr[2:0]} < 4'(nch));
  endfunction
endpackage

// File: rtl/vsm_sequencer.sv
module vsm_sequencer #(
  parameter int NCH   = 7,
  parameter int ADC_W = 10,
  parameter int NAVG  = 16,
  parameter int REG_W = 8,
  localparam int CW    = $clog2(NCH),
  localparam int SW    = $clog2(NAVG),
  localparam int ACC_W = ADC_W + SW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mon_en,
  input  logic             adc_done,
  input  logic [ADC_W-1:0] adc_data,
  output logic             adc_start,
  output logic [CW-1:0]    mux_sel,
  output logic             res_valid,
  output logic [CW-1:0]    res_ch,
  output logic [REG_W-1:0] res_data
);
  import vsm_pkg::*;

  seq_state_t       state;
  logic [CW-1:0]    ch;
  logic [SW-1:0]    cnt;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum_next;

  assign sum_next = acc + ACC_W'(adc_data);
  assign mux_sel  = ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      ch        <= '0;
      cnt       <= '0;
      acc       <= '0;
      adc_start <= 1'b0;
      res_valid <= 1'b0;
      res_ch    <= '0;
      res_data  <= '0;
    end else begin
      adc_start <= 1'b0;
      res_valid <= 1'b0;
      case (state)
        SEQ_IDLE:  if (mon_en) state <= SEQ_START;
        SEQ_START: begin
          adc_start <= 1'b1;
          state     <= SEQ_WAIT;
        end
        SEQ_WAIT: if (adc_done) begin
          if (cnt == SW'(NAVG - 1)) begin
            res_valid <= 1'b1;
            res_ch    <= ch;
            res_data  <= sum_next[ACC_W-1 -: REG_W];
            acc       <= '0;
            cnt       <= '0;
            ch        <= (ch == CW'(NCH - 1)) ? '0 : ch + 1'b1;
            state     <= mon_en ? SEQ_START : SEQ_IDLE;
          end else begin
            acc   <= sum_next;
            cnt   <= cnt + 1'b1;
            state <= SEQ_START;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vsm_regbank.sv
module vsm_regbank #(
  parameter int NCH   = 7,
  parameter int REG_W = 8,
  localparam int CW   = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             res_valid,
  input  logic [CW-1:0]    res_ch,
  input  logic [REG_W-1:0] res_data,
  input  logic [NCH-1:0]   status,
  output logic [REG_W-1:0] cmp_floor,
  output logic [REG_W-1:0] cmp_ceil
);
  import vsm_pkg::*;

  logic [REG_W-1:0] reading_mem [NCH];
  logic [REG_W-1:0] floor_mem   [NCH];
  logic [REG_W-1:0] ceil_mem    [NCH];
  logic [CW-1:0]    idx;

  assign idx       = reg_addr[CW-1:0];
  assign cmp_floor = floor_mem[res_ch];
  assign cmp_ceil  = ceil_mem[res_ch];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        reading_mem[i] <= '0;
        floor_mem[i]   <= '0;
        ceil_mem[i]    <= '1;
      end
    end else begin
      if (res_valid) reading_mem[res_ch] <= res_data;
      if (reg_wr && in_window(reg_addr, MAP_FLOOR, NCH)) floor_mem[idx] <= reg_wdata;
      if (reg_wr && in_window(reg_addr, MAP_CEIL, NCH))  ceil_mem[idx]  <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (in_window(reg_addr, MAP_READING, NCH))     reg_rdata <= reading_mem[idx];
      else if (in_window(reg_addr, MAP_FLOOR, NCH))  reg_rdata <= floor_mem[idx];
      else if (in_window(reg_addr, MAP_CEIL, NCH))   reg_rdata <= ceil_mem[idx];
      else if (reg_addr == MAP_STATUS)               reg_rdata <= REG_W'(status);
      else                                           reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/vsm_status.sv
module vsm_status #(
  parameter int NCH   = 7,
  parameter int REG_W = 8,
  localparam int CW   = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [CW-1:0]    res_ch,
  input  logic [REG_W-1:0] res_data,
  input  logic [REG_W-1:0] cmp_floor,
  input  logic [REG_W-1:0] cmp_ceil,
  input  logic             clr,
  input  logic             alert_en,
  output logic [NCH-1:0]   status_q,
  output logic             alert
);
  logic [NCH-1:0] set_vec;
  logic           outside;

  assign outside = (res_data > cmp_ceil) || (res_data < cmp_floor);

  for (genvar g = 0; g < NCH; g++) begin : g_set
    assign set_vec[g] = res_valid && outside && (res_ch == CW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      alert    <= 1'b0;
    end else begin
      status_q <= (clr ? '0 : status_q) | set_vec;
      alert    <= alert_en && (|status_q);
    end
  end
endmodule

// File: rtl/volt_scan_monitor.sv
module volt_scan_monitor #(
  parameter int NCH   = 7,
  parameter int ADC_W = 10,
  parameter int NAVG  = 16,
  parameter int REG_W = 8,
  localparam int CW   = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mon_en,
  input  logic             alert_en,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             adc_start,
  input  logic             adc_done,
  input  logic [ADC_W-1:0] adc_data,
  output logic [CW-1:0]    mux_sel,
  output logic             alert
);
  import vsm_pkg::*;

  logic             res_valid;
  logic [CW-1:0]    res_ch;
  logic [REG_W-1:0] res_data;
  logic [REG_W-1:0] cmp_floor;
  logic [REG_W-1:0] cmp_ceil;
  logic [NCH-1:0]   status_q;
  logic             stat_clr;

  assign stat_clr = reg_rd && (reg_addr == MAP_STATUS);

  vsm_sequencer #(.NCH(NCH), .ADC_W(ADC_W), .NAVG(NAVG), .REG_W(REG_W)) u_seq (
    .clk(clk), .rst(rst), .mon_en(mon_en), .adc_done(adc_done), .adc_data(adc_data),
    .adc_start(adc_start), .mux_sel(mux_sel), .res_valid(res_valid),
    .res_ch(res_ch), .res_data(res_data)
  );

  vsm_regbank #(.NCH(NCH), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .res_valid(res_valid),
    .res_ch(res_ch), .res_data(res_data), .status(status_q),
    .cmp_floor(cmp_floor), .cmp_ceil(cmp_ceil)
  );

  vsm_status #(.NCH(NCH), .REG_W(REG_W)) u_stat (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_ch(res_ch), .res_data(res_data),
    .cmp_floor(cmp_floor), .cmp_ceil(cmp_ceil), .clr(stat_clr), .alert_en(alert_en),
    .status_q(status_q), .alert(alert)
  );
endmodule

// File: rtl/vsm_checker.sv
module vsm_checker #(
  parameter int NCH  = 7,
  parameter int NAVG = 16,
  localparam int CW  = $clog2(NCH),
  localparam int DW  = $clog2(NAVG) + 1
) (
  input logic           clk,
  input logic           rst,
  input logic           adc_start,
  input logic           adc_done,
  input logic [CW-1:0]  mux_sel,
  input logic           res_valid,
  input logic [NCH-1:0] status_q,
  input logic           alert,
  input logic           alert_en
);
  logic          pending;
  logic [DW-1:0] done_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      done_cnt <= '0;
    end else begin
      if (adc_start)     pending <= 1'b1;
      else if (adc_done) pending <= 1'b0;
      if (res_valid)     done_cnt <= adc_done ? DW'(1) : '0;
      else if (adc_done) done_cnt <= done_cnt + 1'b1;
    end
  end

  assert_start_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> !pending);
  assert_mux_range_R2: assert property (@(posedge clk) disable iff (rst)
    mux_sel < CW'(NCH));
  assert_mux_hold_R2: assert property (@(posedge clk) disable iff (rst)
    pending |-> $stable(mux_sel));
  assert_sixteen_samples_R3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (done_cnt == DW'(NAVG)));
  assert_status_needs_result_R5: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> ((status_q & ~$past(status_q)) == '0));
  assert_alert_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !alert_en |=> !alert);
  assert_alert_source_R8: assert property (@(posedge clk) disable iff (rst)
    alert |-> $past(|status_q));
endmodule

bind volt_scan_monitor vsm_checker #(.NCH(NCH), .NAVG(NAVG)) u_chk (
  .clk(clk), .rst(rst), .adc_start(adc_start), .adc_done(adc_done), .mux_sel(mux_sel),
  .res_valid(res_valid), .status_q(status_q), .alert(alert), .alert_en(alert_en)
);

// File: tb/sim_volt_scan_monitor.sv
`timescale 1ns/1ps
module sim_volt_scan_monitor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mon_en = 1'b0;
  logic       alert_en = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       adc_start;
  logic       adc_done = 1'b0;
  logic [9:0] adc_data = '0;
  logic [2:0] mux_sel;
  logic       alert;

  int checks = 0;
  int errors = 0;
  int conv_total = 0;
  int start_total = 0;
  int ch_log [512];
  int base [7] = '{0, 200, 400, 600, 767, 900, 1020};

  always #4 clk = ~clk;

  volt_scan_monitor u0 (
    .clk(clk), .rst(rst), .mon_en(mon_en), .alert_en(alert_en), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data),
    .mux_sel(mux_sel), .alert(alert)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_reading(input int b);
    // samples b..b+3 repeating: sum = 16b+24, bits [13:6] = (b+1)>>2
    return ((16 * b + 24) / 16) >> 2;
  endfunction

  // behavioural ADC: three cycles latency, sample = base + (conversion index mod 4)
  initial begin
    forever begin
      @(negedge clk);
      if (adc_start) begin
        ch_log[start_total % 512] = int'(mux_sel);
        start_total++;
        @(negedge clk);
        check("R10 start pulse width", int'(adc_start), 0);
        @(negedge clk);
        adc_data = 10'(base[mux_sel] + (conv_total % 4));
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
        conv_total++;
      end
    end
  end

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run_until(input int target);
    mon_en = 1'b1;
    while (conv_total < target - 8) @(negedge clk);
    mon_en = 1'b0;
    while (conv_total < target) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int c = 0; c < 7; c++) begin
      rd(8'(c), d);         check("R1 reading reset", d, 0);
      rd(8'(8'h10 + c), d); check("R1 floor reset", d, 0);
      rd(8'(8'h18 + c), d); check("R1 ceiling reset", d, 255);
    end
    rd(8'h20, d); check("R1 status reset", d, 0);
    check("R1 alert reset", alert, 0);
  endtask

  task automatic t_scan_and_stop;
    logic [7:0] d;
    int act;
    mon_en = 1'b1;
    while (conv_total < 133) @(negedge clk);
    mon_en = 1'b0;
    repeat (300) @(negedge clk);
    check("R9 measurement completes", conv_total, 144);
    check("R9 no start after stop", start_total, 144);
    for (int m = 0; m < 9; m++) begin
      act = ch_log[m * 16];
      for (int k = 1; k < 16; k++) if (ch_log[m * 16 + k] != act) act = 99;
      check("R2 channel order and hold", act, m % 7);
    end
    for (int c = 0; c < 7; c++) begin
      rd(8'(c), d); check("R3 averaged reading", d, exp_reading(base[c]));
    end
    alert_en = 1'b1;
    rd(8'h20, d); check("R6 default limits silent", d, 0);
    repeat (2) @(negedge clk);
    check("R6 no alert with defaults", alert, 0);
    alert_en = 1'b0;
  endtask

  task automatic t_map;
    logic [7:0] d;
    for (int c = 0; c < 7; c++) begin
      wr(8'(8'h10 + c), 8'(c + 3));
      wr(8'(8'h18 + c), 8'(240 - c));
    end
    for (int c = 0; c < 7; c++) begin
      rd(8'(8'h10 + c), d); check("R4 floor readback", d, c + 3);
      rd(8'(8'h18 + c), d); check("R4 ceiling readback", d, 240 - c);
      wr(8'(8'h10 + c), 8'h00);
      wr(8'(8'h18 + c), 8'hFF);
    end
    wr(8'h03, 8'h5A);
    rd(8'h03, d); check("R4 reading is read-only", d, exp_reading(base[3]));
    wr(8'h20, 8'h7F);
    rd(8'h20, d); check("R4 status not writable", d, 0);
  endtask

  task automatic t_limits;
    logic [7:0] d;
    wr(8'h1A, 8'(exp_reading(base[2])));       // ceiling equal: quiet
    wr(8'h1B, 8'(exp_reading(base[3]) - 1));   // ceiling below: fires
    wr(8'h14, 8'(exp_reading(base[4]) + 1));   // floor above: fires
    wr(8'h15, 8'(exp_reading(base[5])));       // floor equal: quiet
    run_until(256);
    check("R8 alert off while disabled", alert, 0);
    alert_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 alert follows status", alert, 1);
    wr(8'h1B, 8'hFF);
    wr(8'h14, 8'h00);
    run_until(368);
    rd(8'h20, d); check("R5 R7 sticky strict violations", d, 8'h18);
    rd(8'h20, d); check("R7 cleared by read", d, 0);
    repeat (3) @(negedge clk);
    check("R8 alert drops after clear", alert, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_scan_and_stop();
    t_map();
    t_limits();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule